// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block walks a block of memory one element at a time. It performs one of five element operations: load into the accumulator, store from the accumulator, copy, scan against the accumulator, or compare two regions. A caller loads the operation, the element size, the walk direction, two pointers, a count and an accumulator value with a one-cycle `start` pulse. The block then drives a single synchronous memory port until the run ends.

Each element moves the pointers that the operation uses by the element size. In repeat mode each element also uses up one count. A run ends when the count is used up. A scan or compare run also ends when the last comparison breaks the selected repeat condition. When a run ends, the block reports the final pointers, the count, the accumulator and a zero flag that holds the result of the latest comparison.

Top module: `strop_seq`

## Requirements
- R1: `size_in` 0, 1 and 2 select elements of 1, 2 and 4 bytes. Each pointer the operation uses moves by exactly that number of bytes per element. Writes enable the low 1, 2 or 4 bits of `mem_be`, where bit b addresses byte `mem_addr`+b.
- R2: With `dir_in` 0 the pointers move up. With `dir_in` 1 they move down. Pointer arithmetic wraps modulo 2^ADDR_W.
- R3: Operation codes are 0 load, 1 store, 2 move, 3 scan and 4 compare. Load moves only the source pointer. Store and scan move only the destination pointer. Move and compare move both. Only store and move write memory. Each element costs one access for load, store and scan, and two for move and compare.
- R4: Load replaces the low element-size bytes of the accumulator with the little-endian data read at the source pointer and keeps the upper bytes. Store writes the low element-size bytes of the accumulator at the destination pointer.
- R5: Move reads the element at the source pointer, and in the next cycle writes those bytes at the destination pointer.
- R6: With `rep_in` 1 the count drops by one after each element and the run ends once it reaches zero. With `rep_in` 0 exactly one element is processed and the count is left unchanged.
- R7: If `rep_in` is 1 and `cx_in` is 0, `done` rises in the cycle after `start`. No memory access occurs, and the pointers, count and accumulator keep their start values.
- R8: Scan compares the low element-size bytes of the accumulator with the element at the destination pointer. Compare compares the element at the source pointer with the element at the destination pointer. `zf_out` is 1 for equal and 0 otherwise. It keeps its value through runs that make no comparison.
- R9: In repeat mode a scan or compare run with `until_eq_in` 0 also ends after the first unequal element. With `until_eq_in` 1 it ends after the first equal element. The stopping element still moves the pointers and uses up a count.
- R10: Read data is taken one cycle after the read request. `busy` is high from the cycle after an accepted start until the cycle after `done`. `done` is a one-cycle pulse. A `start` while busy is ignored, and no access occurs while not busy.
- R11: After reset, `busy`, `done`, `mem_req` and `zf_out` are 0, and the pointers, count and accumulator are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new run (ignored while busy) |
| op_in | input | 3 | Operation code |
| size_in | input | 2 | Element size code |
| rep_in | input | 1 | Repeat under count control |
| until_eq_in | input | 1 | 0: repeat while equal, 1: repeat while not equal |
| dir_in | input | 1 | 0 walk up, 1 walk down |
| si_in | input | ADDR_W | Initial source pointer |
| di_in | input | ADDR_W | Initial destination pointer |
| cx_in | input | CNT_W | Initial count |
| acc_in | input | 32 | Initial accumulator |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | 4 | Write byte enables |
| mem_wdata | output | 32 | Write data, little-endian |
| mem_rdata | input | 32 | Read data, one cycle after request |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (one cycle) |
| si_out | output | ADDR_W | Source pointer |
| di_out | output | ADDR_W | Destination pointer |
| cx_out | output | CNT_W | Count |
| acc_out | output | 32 | Accumulator |
| zf_out | output | 1 | Result of latest comparison |

## Verification
The bench builds the block with ADDR_W = 8 and CNT_W = 5. The whole address space then fits the bench's 256-byte memory, so every access is observed and compared after each run. Downward walks from low addresses and dword accesses near the top of the space both wrap, which brings pointer and byte-address wraparound within reach. Memory filled only with 0 and 1 bytes makes equal and unequal elements both common, so scan and compare runs stop at varied positions in both repeat modes.

// File: rtl/strop_pkg.sv
package strop_pkg;

    localparam int DATA_W     = 32;
    localparam int BYTE_LANES = DATA_W / 8;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_MOVE  = 3'd2,
        OP_SCAN  = 3'd3,
        OP_CMP   = 3'd4
    } strop_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_RD2,
        ST_EVAL,
        ST_WR,
        ST_DONE
    } strop_state_e;

    typedef struct packed {
        strop_op_e   op;
        logic [1:0]  size;
        logic        rep;
        logic        until_eq;
        logic        dir;
    } strop_job_t;

    function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] elem_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return DATA_W'(32'h0000_00FF);
            2'd1:    return DATA_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction

    function automatic logic [BYTE_LANES-1:0] elem_be(input logic [1:0] sz);
        case (sz)
            2'd0:    return BYTE_LANES'(4'b0001);
            2'd1:    return BYTE_LANES'(4'b0011);
            default: return '1;
        endcase
    endfunction

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic walks_src(input strop_op_e op);
        return op == OP_LOAD || op == OP_MOVE || op == OP_CMP;
    endfunction

    function automatic logic walks_dst(input strop_op_e op);
        return op == OP_STORE || op == OP_MOVE || op == OP_SCAN || op == OP_CMP;
    endfunction

    function automatic logic is_compare(input strop_op_e op);
        return op == OP_SCAN || op == OP_CMP;
    endfunction

    function automatic strop_state_e entry_state(input strop_op_e op);
        return (op == OP_STORE) ? ST_WR : ST_RD1;
    endfunction

endpackage

// File: rtl/strop_regs.sv
module strop_regs
    import strop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] si_init,
    input  logic [ADDR_W-1:0] di_init,
    input  logic [CNT_W-1:0]  cx_init,
    input  logic              step,
    input  logic              step_si,
    input  logic              step_di,
    input  logic              count,
    input  logic              dir,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] si,
    output logic [ADDR_W-1:0] di,
    output logic [CNT_W-1:0]  cx,
    output logic              cx_last
);

    localparam int NPTR = 2;

    logic [ADDR_W-1:0] delta;
    logic [NPTR-1:0]   walk;
    logic [ADDR_W-1:0] init_v [NPTR];

    assign delta     = ADDR_W'(elem_bytes(size));
    assign walk      = {step_di, step_si};
    assign init_v[0] = si_init;
    assign init_v[1] = di_init;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        logic [ADDR_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (load) begin
                q <= init_v[g];
            end else if (step && walk[g]) begin
                q <= dir ? (q - delta) : (q + delta);
            end
        end
    end

    assign si = g_ptr[0].q;
    assign di = g_ptr[1].q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cx <= '0;
        end else if (load) begin
            cx <= cx_init;
        end else if (step && count) begin
            cx <= cx - CNT_W'(1);
        end
    end

    assign cx_last = (cx == CNT_W'(1));

    // Source pointer moves by one element in the selected direction
    assert_si_step_R1: assert property (@(posedge clk) disable iff (rst)
        (step && step_si && !load) |=>
            (($past(dir) ? ($past(si) - si) : (si - $past(si))) == $past(delta)));

    // Destination pointer follows the direction flag
    assert_di_step_R2: assert property (@(posedge clk) disable iff (rst)
        (step && step_di && !load) |=>
            (($past(dir) ? ($past(di) - di) : (di - $past(di))) == $past(delta)));

    assert_di_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !step_di && !load) |=> $stable(di));

    assert_cx_count_R6: assert property (@(posedge clk) disable iff (rst)
        (step && count && !load) |=> (cx == $past(cx) - CNT_W'(1)));

endmodule

// File: rtl/strop_lane.sv
module strop_lane
    import strop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  strop_op_e         op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] rdata,
    output logic              eq,
    output logic [DATA_W-1:0] acc_merged,
    output logic [DATA_W-1:0] wdata
);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] held;
    logic [DATA_W-1:0] ref_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (capture) begin
            held <= rdata;
        end
    end

    assign mask       = elem_mask(size);
    assign ref_val    = (op == OP_CMP) ? held : acc;
    assign eq         = ((ref_val ^ rdata) & mask) == '0;
    assign acc_merged = (acc & ~mask) | (rdata & mask);
    assign wdata      = ((op == OP_MOVE) ? rdata : acc) & mask;

endmodule

// File: rtl/strop_fsm.sv
module strop_fsm
    import strop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  strop_job_t job_in,
    input  logic       cx_init_zero,
    input  logic       cx_last,
    input  logic       eq,
    output strop_job_t job,
    output logic       load,
    output logic       mem_req,
    output logic       mem_we,
    output logic       addr_di,
    output logic       capture,
    output logic       step,
    output logic       acc_load,
    output logic       zf_load,
    output logic       busy,
    output logic       done
);

    strop_state_e state, nxt;
    logic         finish;

    assign finish = !job.rep || cx_last ||
                    (is_compare(job.op) && (job.until_eq ? eq : !eq));

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        addr_di  = 1'b0;
        capture  = 1'b0;
        step     = 1'b0;
        acc_load = 1'b0;
        zf_load  = 1'b0;
        done     = 1'b0;
        case (state)
            ST_IDLE: begin
                load = start;
                if (start) begin
                    if ((job_in.rep && cx_init_zero) || !op_known(job_in.op)) begin
                        nxt = ST_DONE;
                    end else begin
                        nxt = entry_state(job_in.op);
                    end
                end
            end
            ST_RD1: begin
                mem_req = 1'b1;
                addr_di = (job.op == OP_SCAN);
                nxt     = (job.op == OP_CMP) ? ST_RD2 : ST_EVAL;
            end
            ST_RD2: begin
                mem_req = 1'b1;
                addr_di = 1'b1;
                capture = 1'b1;
                nxt     = ST_EVAL;
            end
            ST_EVAL: begin
                step     = 1'b1;
                acc_load = (job.op == OP_LOAD);
                zf_load  = is_compare(job.op);
                if (job.op == OP_MOVE) begin
                    mem_req = 1'b1;
                    mem_we  = 1'b1;
                    addr_di = 1'b1;
                end
                nxt = finish ? ST_DONE : entry_state(job.op);
            end
            ST_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                addr_di = 1'b1;
                step    = 1'b1;
                nxt     = finish ? ST_DONE : ST_WR;
            end
            ST_DONE: begin
                done = 1'b1;
                nxt  = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            job   <= '0;
        end else begin
            state <= nxt;
            if (load) begin
                job <= job_in;
            end
        end
    end

    assign busy = (state != ST_IDLE);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_empty_run_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && job_in.rep && cx_init_zero) |=> (done && !mem_req));

    assert_write_ops_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (job.op == OP_STORE || job.op == OP_MOVE));

    assert_step_busy_R6: assert property (@(posedge clk) disable iff (rst)
        step |-> busy);

endmodule

// File: rtl/strop_seq.sv
module strop_seq
    import strop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [2:0]            op_in,
    input  logic [1:0]            size_in,
    input  logic                  rep_in,
    input  logic                  until_eq_in,
    input  logic                  dir_in,
    input  logic [ADDR_W-1:0]     si_in,
    input  logic [ADDR_W-1:0]     di_in,
    input  logic [CNT_W-1:0]      cx_in,
    input  logic [31:0]           acc_in,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [3:0]            mem_be,
    output logic [31:0]           mem_wdata,
    input  logic [31:0]           mem_rdata,
    output logic                  busy,
    output logic                  done,
    output logic [ADDR_W-1:0]     si_out,
    output logic [ADDR_W-1:0]     di_out,
    output logic [CNT_W-1:0]      cx_out,
    output logic [31:0]           acc_out,
    output logic                  zf_out
);

    strop_job_t        job_in, job;
    logic              load, addr_di, capture, step, acc_load, zf_load;
    logic              cx_last, eq;
    logic [DATA_W-1:0] acc_merged, wdata;
    logic [DATA_W-1:0] acc_q;
    logic              zf_q;

    assign job_in = '{op:       strop_op_e'(op_in),
                      size:     size_in,
                      rep:      rep_in,
                      until_eq: until_eq_in,
                      dir:      dir_in};

    strop_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .job_in       (job_in),
        .cx_init_zero (cx_in == '0),
        .cx_last      (cx_last),
        .eq           (eq),
        .job          (job),
        .load         (load),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .addr_di      (addr_di),
        .capture      (capture),
        .step         (step),
        .acc_load     (acc_load),
        .zf_load      (zf_load),
        .busy         (busy),
        .done         (done)
    );

    strop_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .si_init (si_in),
        .di_init (di_in),
        .cx_init (cx_in),
        .step    (step),
        .step_si (walks_src(job.op)),
        .step_di (walks_dst(job.op)),
        .count   (job.rep),
        .dir     (job.dir),
        .size    (job.size),
        .si      (si_out),
        .di      (di_out),
        .cx      (cx_out),
        .cx_last (cx_last)
    );

    strop_lane u_lane (
        .clk        (clk),
        .rst        (rst),
        .capture    (capture),
        .op         (job.op),
        .size       (job.size),
        .acc        (acc_q),
        .rdata      (mem_rdata),
        .eq         (eq),
        .acc_merged (acc_merged),
        .wdata      (wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            zf_q  <= 1'b0;
        end else begin
            if (load) begin
                acc_q <= acc_in;
            end else if (acc_load) begin
                acc_q <= acc_merged;
            end
            if (zf_load) begin
                zf_q <= eq;
            end
        end
    end

    assign mem_addr  = addr_di ? di_out : si_out;
    assign mem_be    = elem_be(job.size);
    assign mem_wdata = wdata;
    assign acc_out   = acc_q;
    assign zf_out    = zf_q;

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    assert_acc_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_load && job.size == 2'd0) |=> (acc_q[31:8] == $past(acc_q[31:8])));

    assert_zf_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !is_compare(job.op)) |=> $stable(zf_q));

endmodule

// File: tb/strop_seq_bench.sv
`timescale 1ns/1ps
module strop_seq_bench;
    localparam int AW = 8;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    op_in = '0;
    logic [1:0]    size_in = '0;
    logic          rep_in = 1'b0, until_eq_in = 1'b0, dir_in = 1'b0;
    logic [AW-1:0] si_in = '0, di_in = '0;
    logic [CW-1:0] cx_in = '0;
    logic [31:0]   acc_in = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [31:0]   rdata_q = '0;
    logic          busy, done;
    logic [AW-1:0] si_out, di_out;
    logic [CW-1:0] cx_out;
    logic [31:0]   acc_out;
    logic          zf_out;

    int n_chk = 0;
    int n_bad = 0;
    logic zf_m = 1'b0;

    logic [7:0]  mem [256];
    logic [7:0]  mdl [256];
    int unsigned access_cnt = 0;
    logic        reseed = 1'b0;
    logic [31:0] seed_q = '0;
    logic        small_q = 1'b0;

    always #10 clk = ~clk;

    strop_seq #(.ADDR_W(AW), .CNT_W(CW)) u_strop_seq (
        .clk(clk), .rst(rst), .start(start), .op_in(op_in), .size_in(size_in),
        .rep_in(rep_in), .until_eq_in(until_eq_in), .dir_in(dir_in),
        .si_in(si_in), .di_in(di_in), .cx_in(cx_in), .acc_in(acc_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(rdata_q), .busy(busy), .done(done),
        .si_out(si_out), .di_out(di_out), .cx_out(cx_out), .acc_out(acc_out),
        .zf_out(zf_out)
    );

    function automatic logic [7:0] pat(input logic [31:0] s, input int i, input logic sm);
        logic [31:0] x;
        x = s ^ (32'(i) * 32'h9E37_79B1);
        x = x ^ (x >> 15);
        x = x * 32'h2C1B_3C6D;
        x = x ^ (x >> 12);
        return sm ? {7'b0, x[3]} : x[7:0];
    endfunction

    always @(posedge clk) begin
        if (reseed) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(seed_q, i, small_q);
        end else if (mem_req) begin
            access_cnt <= access_cnt + 1;
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[8'(mem_addr + 8'(b))] <= mem_wdata[8*b +: 8];
            end else begin
                rdata_q <= {mem[8'(mem_addr + 8'd3)], mem[8'(mem_addr + 8'd2)],
                            mem[8'(mem_addr + 8'd1)], mem[mem_addr]};
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [31:0] s, input logic sm);
        @(negedge clk);
        seed_q = s; small_q = sm; reseed = 1'b1;
        @(negedge clk);
        reseed = 1'b0;
    endtask

    function automatic logic [31:0] mrd(input logic [7:0] a);
        return {mdl[8'(a + 8'd3)], mdl[8'(a + 8'd2)], mdl[8'(a + 8'd1)], mdl[a]};
    endfunction

    task automatic mwr(input logic [7:0] a, input logic [31:0] v, input int nb);
        for (int b = 0; b < nb; b++) mdl[8'(a + 8'(b))] = v[8*b +: 8];
    endtask

    task automatic run_op(input string tag, input logic [2:0] op, input logic [1:0] sz,
                          input logic rep, input logic ueq, input logic dr,
                          input logic [7:0] si0, input logic [7:0] di0,
                          input logic [4:0] cx0, input logic [31:0] acc0, input logic poke);
        logic [7:0]  si, di;
        logic [4:0]  cx;
        logic [31:0] acc, msk, a, b;
        int          nb, nacc, waited, bad_bytes;
        int unsigned cnt0;
        logic        stop;
        si = si0; di = di0; cx = cx0; acc = acc0; nacc = 0;
        nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        msk = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
        for (int i = 0; i < 256; i++) mdl[i] = mem[i];
        stop = rep && (cx == 0);
        while (!stop) begin
            case (op)
                3'd0: begin a = mrd(si); acc = (acc & ~msk) | (a & msk); nacc += 1; end
                3'd1: begin mwr(di, acc, nb); nacc += 1; end
                3'd2: begin a = mrd(si); mwr(di, a, nb); nacc += 2; end
                3'd3: begin b = mrd(di); zf_m = ((acc ^ b) & msk) == 0; nacc += 1; end
                default: begin a = mrd(si); b = mrd(di); zf_m = ((a ^ b) & msk) == 0; nacc += 2; end
            endcase
            if (op == 3'd0 || op == 3'd2 || op == 3'd4) si = dr ? si - 8'(nb) : si + 8'(nb);
            if (op != 3'd0) di = dr ? di - 8'(nb) : di + 8'(nb);
            if (rep) cx = cx - 5'd1;
            stop = !rep || cx == 0 || ((op == 3'd3 || op == 3'd4) && (ueq ? zf_m : !zf_m));
        end

        @(negedge clk);
        op_in = op; size_in = sz; rep_in = rep; until_eq_in = ueq; dir_in = dr;
        si_in = si0; di_in = di0; cx_in = cx0; acc_in = acc0; start = 1'b1;
        cnt0 = access_cnt;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R10: start while busy must be ignored
            op_in = 3'd1; si_in = 8'h11; di_in = 8'h22; cx_in = 5'd1; acc_in = 32'hDEAD_BEEF;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " R10"}, "done seen", 32'(done), 32'd1);
        if (rep && cx0 == 0) chk({tag, " R7"}, "cycles to done", 32'(waited), 32'd0);
        chk({tag, " R2"}, "si", 32'(si_out), 32'(si));
        chk({tag, " R2"}, "di", 32'(di_out), 32'(di));
        chk({tag, " R6"}, "cx", 32'(cx_out), 32'(cx));
        chk({tag, " R4"}, "acc", acc_out, acc);
        chk({tag, " R8"}, "zf", 32'(zf_out), 32'(zf_m));
        chk({tag, " R3"}, "accesses", 32'(access_cnt - cnt0), 32'(nacc));
        bad_bytes = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== mdl[i]) bad_bytes++;
        chk({tag, " R5"}, "mismatching bytes", 32'(bad_bytes), 32'd0);
        @(negedge clk);
        chk({tag, " R10"}, "done pulse/busy low", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "busy", 32'(busy), 32'd0);
        chk("R11", "done", 32'(done), 32'd0);
        chk("R11", "mem_req", 32'(mem_req), 32'd0);
        chk("R11", "si/di/cx", {11'd0, si_out, di_out, cx_out}, 32'd0);
        chk("R11", "acc", acc_out, 32'd0);
        chk("R11", "zf", 32'(zf_out), 32'd0);

        fill(32'd5, 1'b0);
        run_op("R7",  3'd0, 2'd2, 1'b1, 1'b0, 1'b0, 8'h40, 8'h80, 5'd0, 32'h1234_5678, 1'b0);
        run_op("R1",  3'd1, 2'd0, 1'b1, 1'b0, 1'b0, 8'h10, 8'h20, 5'd4, 32'hAABB_CCDD, 1'b0);
        run_op("R1",  3'd1, 2'd1, 1'b1, 1'b0, 1'b0, 8'h10, 8'h30, 5'd3, 32'h0102_0304, 1'b0);
        run_op("R2",  3'd1, 2'd2, 1'b1, 1'b0, 1'b1, 8'h00, 8'h02, 5'd3, 32'hCAFE_F00D, 1'b0);
        run_op("R2",  3'd0, 2'd2, 1'b1, 1'b0, 1'b0, 8'hFC, 8'h00, 5'd2, 32'h0, 1'b0);
        run_op("R4",  3'd0, 2'd1, 1'b0, 1'b0, 1'b0, 8'h51, 8'h00, 5'd9, 32'h7777_7777, 1'b0);
        run_op("R6",  3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 8'h61, 8'h00, 5'd7, 32'h1111_1111, 1'b0);
        run_op("R6",  3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 8'h61, 8'h00, 5'd31, 32'h1111_1111, 1'b0);
        run_op("R5",  3'd2, 2'd1, 1'b1, 1'b0, 1'b0, 8'h80, 8'hA0, 5'd4, 32'h0, 1'b1);
        fill(32'd77, 1'b1);
        run_op("R8",  3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h30, 5'd5, 32'h0000_0001, 1'b0);
        run_op("R9",  3'd4, 2'd0, 1'b1, 1'b0, 1'b0, 8'h10, 8'h90, 5'd12, 32'h0, 1'b0);
        run_op("R9",  3'd4, 2'd0, 1'b1, 1'b1, 1'b1, 8'h50, 8'hC0, 5'd12, 32'h0, 1'b0);
        run_op("R9",  3'd3, 2'd1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h20, 5'd10, 32'h0000_0101, 1'b0);
        run_op("R7",  3'd4, 2'd0, 1'b1, 1'b0, 1'b0, 8'h10, 8'h90, 5'd0, 32'h0, 1'b0);

        for (int k = 0; k < 40; k++) begin
            logic sm;
            sm = $urandom_range(0, 1) == 1;
            fill($urandom, sm);
            run_op("R9 rnd", 3'($urandom_range(0, 4)), 2'($urandom_range(0, 2)),
                   $urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   8'($urandom), 8'($urandom), 5'($urandom_range(0, 9)),
                   sm ? ($urandom & 32'h0101_0101) : $urandom, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule